// File: doc/BRIEF.md
# Packed SIMD Per-Lane Variable Shifter

The block shifts every element of a packed data vector by its own amount. The amount comes from the matching element of a second packed vector. A control bit picks the active vector width: 128 bits, or only the low 64 bits. A 2-bit size code splits the vector into 8, 16, 32 or 64-bit lanes.

Each lane uses only the low byte of its control element. That byte is read as a signed count. A positive count shifts the lane left and a negative count shifts it right. In both directions the vacated bits fill with zeros. Any count whose magnitude reaches the lane width gives a zero lane.

In 64-bit mode the upper half of the result is forced to zero. The combination of 64-bit lanes with 64-bit mode is reserved: the block raises a flag and drives a zero result. The datapath is combinational. An optional output register, loaded only on a valid input, carries the result and the flag to a valid output one cycle later.

Top module: `vshift_unit`

## Requirements
- R1: Size code `size_i` selects the lane width as 8 shifted left by the code: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane k occupies bits [k*w + w-1 : k*w] of the operands and of the result.
- R2: When `q_i` is 1, all 128 bits hold lanes. When `q_i` is 0, only bits [63:0] hold lanes and result bits [127:64] are zero.
- R3: `q_i` = 0 together with `size_i` = 3 is reserved. For this combination `reserved_o` is 1 and the result is all zeros. For every other combination `reserved_o` is 0.
- R4: A lane's shift count is bits [7:0] of that lane in `opb_i`, read as two's complement. The control lane's bits above bit 7 have no effect.
- R5: A positive count c below the lane width shifts the lane left by c. Bits shifted past the top of the lane are lost, and the low bits fill with zeros.
- R6: A negative count -c with c below the lane width shifts the lane right logically by c, filling the top bits with zeros.
- R7: A count at or above the lane width, or at or below minus the lane width, gives a zero lane. This includes 127 and -128 (0x80) in any lane width.
- R8: A count of zero passes the lane through unchanged.
- R9: With the output register enabled, `valid_o` rises exactly one cycle after `valid_i`, and `result_o` and `reserved_o` belong to that input. After reset, `valid_o`, `result_o` and `reserved_o` are 0.
- R10: With the output register enabled, a cycle where `valid_i` is low leaves `result_o` and `reserved_o` unchanged, whatever the operands do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input operands are valid |
| q_i | input | 1 | 1: 128-bit vector, 0: 64-bit vector |
| size_i | input | 2 | Lane size code |
| opa_i | input | 128 | Data vector to be shifted |
| opb_i | input | 128 | Per-lane shift count vector |
| valid_o | output | 1 | Result is valid |
| reserved_o | output | 1 | Reserved encoding was given |
| result_o | output | 128 | Shifted vector |

## Verification
The checker assumes `valid_i`, `q_i` and `size_i` carry known 0/1 values at every rising edge once reset is released. Without that, the latency, hold and reserved-flag relations would compare unknown values. The bench changes every input only on the falling clock edge and fills the operands completely, either from the vector table or from `$urandom`, so no unknown bit reaches a sampling edge. Reset is held across the first edges, so the properties are never armed on values from before initialisation.

// File: rtl/vshift_pkg.sv
package vshift_pkg;
  localparam int SIZE_W = 2;
  localparam int AMT_W  = 8;

  typedef enum logic [SIZE_W-1:0] {
    ES_8  = 2'd0,
    ES_16 = 2'd1,
    ES_32 = 2'd2,
    ES_64 = 2'd3
  } esize_e;

  function automatic int lane_bits(input int code);
    return 8 << code;
  endfunction
endpackage

// File: rtl/vshift_decode.sv
module vshift_decode
  import vshift_pkg::*;
(
  input  logic              q_i,
  input  logic [SIZE_W-1:0] size_i,
  output esize_e            es_o,
  output logic              half_o,
  output logic              rsv_o
);
  assign es_o   = esize_e'(size_i);
  assign half_o = ~q_i;
  // 64-bit lanes need the full 128-bit vector
  assign rsv_o  = (es_o == ES_64) && ~q_i;
endmodule

// File: rtl/vshift_lane.sv
module vshift_lane
  import vshift_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]     x_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [W-1:0]     y_o
);
  localparam logic [AMT_W:0] LIM = (AMT_W+1)'(W);

  logic             neg;
  logic [AMT_W-1:0] mag;
  logic             over;

  always_comb begin
    neg  = amt_i[AMT_W-1];
    // magnitude of -128 is 128, fits unsigned 8 bits
    mag  = neg ? (~amt_i + 1'b1) : amt_i;
    over = {1'b0, mag} >= LIM;
    if (over)     y_o = '0;
    else if (neg) y_o = x_i >> mag;
    else          y_o = x_i << mag;
  end
endmodule

// File: rtl/vshift_array.sv
module vshift_array
  import vshift_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  esize_e           es_i,
  output logic [VEC_W-1:0] res_o
);
  localparam int N_SIZES = 1 << SIZE_W;

  logic [N_SIZES-1:0][VEC_W-1:0] per_size;

  for (genvar s = 0; s < N_SIZES; s++) begin : g_size
    localparam int LW = lane_bits(s);
    localparam int NL = VEC_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      vshift_lane #(.W(LW)) i_lane (
        .x_i  (a_i[l*LW +: LW]),
        .amt_i(b_i[l*LW +: AMT_W]),
        .y_o  (per_size[s][l*LW +: LW])
      );
    end
  end

  assign res_o = per_size[es_i];
endmodule

// File: rtl/vshift_unit.sv
module vshift_unit
  import vshift_pkg::*;
#(
  parameter int VEC_W   = 128,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              q_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [VEC_W-1:0]  opa_i,
  input  logic [VEC_W-1:0]  opb_i,
  output logic              valid_o,
  output logic              reserved_o,
  output logic [VEC_W-1:0]  result_o
);
  localparam int HALF_W = VEC_W / 2;

  esize_e             es;
  logic               half;
  logic               rsv;
  logic [VEC_W-1:0]   raw;
  logic [VEC_W-1:0]   res_d;
  logic               q_q;
  logic [SIZE_W-1:0]  size_q;

  vshift_decode i_decode (
    .q_i   (q_i),
    .size_i(size_i),
    .es_o  (es),
    .half_o(half),
    .rsv_o (rsv)
  );

  vshift_array #(.VEC_W(VEC_W)) i_array (
    .a_i  (opa_i),
    .b_i  (opb_i),
    .es_i (es),
    .res_o(raw)
  );

  always_comb begin
    res_d = raw;
    if (rsv)       res_d = '0;
    else if (half) res_d[VEC_W-1:HALF_W] = '0;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o    <= 1'b0;
        reserved_o <= 1'b0;
        result_o   <= '0;
        q_q        <= 1'b0;
        size_q     <= '0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) begin
          reserved_o <= rsv;
          result_o   <= res_d;
          q_q        <= q_i;
          size_q     <= size_i;
        end
      end
    end
  end else begin : g_comb
    assign valid_o    = valid_i;
    assign reserved_o = rsv;
    assign result_o   = res_d;
    assign q_q        = q_i;
    assign size_q     = size_i;
  end
endmodule

// File: rtl/vshift_chk.sv
module vshift_chk #(
  parameter int VEC_W   = 128,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             valid_o,
  input logic             reserved_o,
  input logic [VEC_W-1:0] result_o,
  input logic             q_q,
  input logic [1:0]       size_q
);
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && reserved_o |-> result_o == '0); // R3
  AST_RSV_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> reserved_o == (size_q == 2'd3 && !q_q)); // R3
  AST_UPPER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !q_q |-> result_o[VEC_W-1:VEC_W/2] == '0); // R2

  if (REG_OUT) begin : g_reg_chk
    AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o); // R9
    AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o); // R9
    AST_HOLD_RES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(result_o) && $stable(reserved_o)); // R10
  end
endmodule

bind vshift_unit vshift_chk #(.VEC_W(VEC_W), .REG_OUT(REG_OUT)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .valid_o   (valid_o),
  .reserved_o(reserved_o),
  .result_o  (result_o),
  .q_q       (q_q),
  .size_q    (size_q)
);

// File: tb/test_vshift_unit.sv
`timescale 1ns/1ps
module test_vshift_unit;
  typedef struct packed {
    logic         q;
    logic [1:0]   sz;
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] e;
    logic         rsv;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'd0, {16{8'h81}}, {16{8'h01}}, {16{8'h02}}, 1'b0},               // R5
    '{1'b1, 2'd0, {16{8'h81}}, {16{8'hFF}}, {16{8'h40}}, 1'b0},               // R6
    '{1'b1, 2'd0, {16{8'h81}}, {16{8'h80}}, 128'h0, 1'b0},                    // R7 -128
    '{1'b1, 2'd0, {16{8'h81}}, {16{8'h07}}, {16{8'h80}}, 1'b0},               // R5 7
    '{1'b1, 2'd0, {16{8'h81}}, {16{8'h08}}, 128'h0, 1'b0},                    // R7 +8
    '{1'b1, 2'd0, {16{8'h81}}, {16{8'hF8}}, 128'h0, 1'b0},                    // R7 -8
    '{1'b1, 2'd0, {16{8'h81}}, {16{8'hF9}}, {16{8'h01}}, 1'b0},               // R6 -7
    '{1'b1, 2'd1, {8{16'h8001}}, {8{16'hFF04}}, {8{16'h0010}}, 1'b0},         // R4 R1
    '{1'b1, 2'd2, {4{32'h12345678}}, {4{32'h000000F0}}, {4{32'h00001234}}, 1'b0}, // R6 R1
    '{1'b1, 2'd3, {2{64'h0123456789ABCDEF}}, {2{64'h3F}}, {2{64'h8000000000000000}}, 1'b0}, // R5
    '{1'b1, 2'd3, {2{64'h0123456789ABCDEF}}, {2{64'h40}}, 128'h0, 1'b0},      // R7
    '{1'b0, 2'd2, {4{32'hFFFFFFFF}}, 128'h0, {64'h0, {2{32'hFFFFFFFF}}}, 1'b0}, // R2 R8
    '{1'b0, 2'd3, {2{64'hFFFFFFFFFFFFFFFF}}, 128'h0, 128'h0, 1'b1},           // R3
    '{1'b1, 2'd1, {8{16'hABCD}}, {8{16'h007F}}, 128'h0, 1'b0},                // R7 127
    '{1'b0, 2'd0, {16{8'h0F}}, {16{8'h02}}, {64'h0, {8{8'h3C}}}, 1'b0},       // R2 R5
    '{1'b1, 2'd3, {2{64'h8000000000000000}}, {2{64'hC1}}, {2{64'h1}}, 1'b0}   // R6 -63
  };

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic         q_i = 1'b0;
  logic [1:0]   size_i = '0;
  logic [127:0] opa_i = '0;
  logic [127:0] opb_i = '0;
  logic         valid_o;
  logic         reserved_o;
  logic [127:0] result_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vshift_unit i_vshift_unit (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .q_i       (q_i),
    .size_i    (size_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .valid_o   (valid_o),
    .reserved_o(reserved_o),
    .result_o  (result_o)
  );

  function automatic logic [127:0] model(input logic q, input logic [1:0] sz,
                                         input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r = '0;
    int es = 8 << sz;
    logic [127:0] mask = (128'd1 << es) - 128'd1;
    if (sz == 2'd3 && !q) return '0;
    for (int l = 0; l < 128 / es; l++) begin
      logic [127:0] x = (a >> (l*es)) & mask;
      logic [7:0]   c = b[l*es +: 8];
      int amt = c[7] ? int'(c) - 256 : int'(c);
      logic [127:0] y;
      if (!q && l*es >= 64) y = '0;
      else if (amt >= es || amt <= -es) y = '0;
      else if (amt < 0) y = x >> (-amt);
      else y = (x << amt) & mask;
      r |= y << (l*es);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic q, input logic [1:0] sz,
                       input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    valid_i = 1'b1; q_i = q; size_i = sz; opa_i = a; opb_i = b;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] last;
    repeat (3) @(negedge clk);
    check("R9 reset valid", {127'h0, valid_o}, 128'h0);
    check("R9 reset result", result_o, 128'h0);
    check("R9 reset rsv", {127'h0, reserved_o}, 128'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i].q, TBL[i].sz, TBL[i].a, TBL[i].b);
      check($sformatf("R1 R5 R6 R7 table %0d result", i), result_o, TBL[i].e);
      check($sformatf("R3 table %0d rsv", i), {127'h0, reserved_o}, {127'h0, TBL[i].rsv});
      check($sformatf("R9 table %0d valid", i), {127'h0, valid_o}, 128'h1);
    end

    // R10 R9: idle cycle keeps outputs, drops valid
    last = result_o;
    q_i = 1'b1; size_i = 2'd0; opa_i = {4{32'hDEADBEEF}}; opb_i = '0;
    @(negedge clk);
    check("R9 idle valid", {127'h0, valid_o}, 128'h0);
    check("R10 hold result", result_o, last);
    check("R10 hold rsv", {127'h0, reserved_o}, 128'h0);

    // R8 zero count all sizes
    for (int s = 0; s < 4; s++) begin
      logic [127:0] a = {$urandom, $urandom, $urandom, $urandom};
      apply(1'b1, 2'(s), a, '0);
      check("R8 passthrough", result_o, a);
    end

    // R4 R7 boundary counts with random upper control bits
    for (int s = 0; s < 4; s++) begin
      int es = 8 << s;
      int amts[6] = '{es-1, -(es-1), es, -es, 127, -128};
      for (int k = 0; k < 6; k++) begin
        logic [127:0] a = {$urandom, $urandom, $urandom, $urandom};
        logic [127:0] b = {$urandom, $urandom, $urandom, $urandom};
        for (int l = 0; l < 128 / es; l++) b[l*es +: 8] = 8'(amts[k]);
        apply(1'b1, 2'(s), a, b);
        check($sformatf("R4 R7 boundary s=%0d amt=%0d", s, amts[k]), result_o, model(1'b1, 2'(s), a, b));
      end
    end

    // random mixed lanes, both widths
    for (int i = 0; i < 300; i++) begin
      logic q = 1'($urandom);
      logic [1:0] s = 2'($urandom);
      logic [127:0] a = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] b = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom % 2 == 0)
        for (int l = 0; l < 16; l++) b[l*8 +: 8] = 8'(int'($urandom % 33) - 16);
      apply(q, s, a, b);
      check("R1 R2 R5 R6 random", result_o, model(q, s, a, b));
      check("R3 random rsv", {127'h0, reserved_o}, {127'h0, (s == 2'd3 && !q)});
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule